// File: doc/BRIEF.md
# FPGA Configuration Image Loader

This block lets a host CPU load one of two configuration images from a local SRAM into a target FPGA. The CPU uses a small 8-bit register port, which it can reach at every cycle, for control, status, diagnostics and local reset. A 32-bit path gives the CPU read and write access to the shared SRAM/flash, and the CPU uses it to stage the images.

To start a load, the CPU writes the start bit and picks an image. The controller then takes the 32-bit memory path for itself and shuts the CPU out of it. It reads the image word by word and streams each word out as two 16-bit beats on the programming bus. It holds the FPGA in reset for the whole transfer. When the last beat has gone out, it reports completion and gives the memory path back to the CPU.

Top module: `cfgdma_top`

## Requirements
- R1: The 8-bit register port stays usable during a load. A write to the scratch register (address 6) while busy is read back unchanged afterwards.
- R2: While idle, a CPU access on the 32-bit path reaches the memory. `cpu_ack` rises one cycle after `cpu_req`, and read data is valid in that same cycle.
- R3: While busy, a CPU access is acknowledged but does not reach the memory. Reads return zero and writes are dropped.
- R4: A CPU access while busy sets the sticky violation flag (status bit 3). Writing control bit 3 clears this flag, the error flag and the done flag.
- R5: Writing control (address 0) with bit 0 set starts a load. Bit 1 selects the image. Image 0 uses base/count registers 2/3 and image 1 uses registers 4/5.
- R6: Each word is sent low half first, then high half. Beats are valid in back-to-back cycles. The first beat is valid two cycles after the start write edge. Word addresses step by one, modulo 256.
- R7: `fpga_rst_n` is low from the cycle after the start write until the last beat has been sent. Before and after that it is high.
- R8: Busy (status bit 0) is set from the cycle after the start write. Done (status bit 1) rises and busy falls one cycle after the last beat. A new start clears done.
- R9: A start whose selected count is zero sets the sticky error flag (status bit 2). No load begins.
- R10: A start written while a load is running is ignored. The running load carries on with its original image and count.
- R11: `loc_rst_n` is low while `rst_n` is low. After reset it follows the inverse of control bit 2, updated at the write edge.
- R12: After reset, status reads zero, `prog_valid` is low and `fpga_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and for the programming bus |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 3 | Register port address |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data, combinational on `reg_addr` |
| cpu_req | input | 1 | CPU request on the 32-bit memory path |
| cpu_we | input | 1 | CPU write enable for the request |
| cpu_addr | input | 8 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | Completion of the CPU access, one cycle after the request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the request |
| prog_data | output | 16 | Programming bus data beat |
| prog_valid | output | 1 | Programming beat valid |
| fpga_rst_n | output | 1 | Active-low reset held on the target during a load |
| loc_rst_n | output | 1 | Active-low local reset for the assembly |

## Verification
The bench walks a table of loads with different images, lengths and an address range that wraps past 255. For each load it rebuilds the expected beat stream from the memory contents. A design that sent the halves in the wrong order, stalled between words or read the wrong image's registers would fail the beat-data or timing checks. In one long load the bench reads, writes, restarts and touches the scratch register in the middle of the transfer. A leaky arbiter would return real data or corrupt the memory, and a restart that was not ignored would shorten the beat stream. It also checks a zero-length start, the edge where done and busy change, the sticky-flag clear and the local reset.

// File: rtl/cfgdma_pkg.sv
// Package: shared constants, register addresses and sequencer states for the
// configuration image loader. Assumes one memory word carries two beats.
package cfgdma_pkg;
    localparam int REG_W  = 8;
    localparam int REG_AW = 3;
    localparam int DATA_W = 32;
    localparam int BEAT_W = 16;

    localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
    localparam logic [REG_AW-1:0] RA_STATUS  = 3'd1;
    localparam logic [REG_AW-1:0] RA_BASE0   = 3'd2;
    localparam logic [REG_AW-1:0] RA_CNT0    = 3'd3;
    localparam logic [REG_AW-1:0] RA_BASE1   = 3'd4;
    localparam logic [REG_AW-1:0] RA_CNT1    = 3'd5;
    localparam logic [REG_AW-1:0] RA_SCRATCH = 3'd6;

    localparam int CB_START = 0;
    localparam int CB_IMG   = 1;
    localparam int CB_SOFT  = 2;
    localparam int CB_CLR   = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LO,
        S_HI,
        S_FIN
    } seq_state_t;
endpackage

// File: rtl/cfgdma_regs.sv
// Register file: control, status, image descriptors, scratch and local reset.
// Assumes writes take effect at the clock edge and reads are combinational.
module cfgdma_regs
    import cfgdma_pkg::*;
#(
    parameter int RW  = REG_W,
    parameter int RAW = REG_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RW-1:0]  reg_wdata,
    output logic [RW-1:0]  reg_rdata,
    input  logic           busy,
    input  logic           fin_pulse,
    input  logic           err_set,
    input  logic           viol_set,
    output logic           start_req,
    output logic           start_img,
    output logic [RW-1:0]  base0,
    output logic [RW-1:0]  cnt0,
    output logic [RW-1:0]  base1,
    output logic [RW-1:0]  cnt1,
    output logic           loc_rst_n
);
    logic          wr_ctrl, clr;
    logic          img_q, soft_q, done_q, err_q, viol_q;
    logic [RW-1:0] scratch_q;

    // Decode control-register write strobes.
    assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
    assign start_req = wr_ctrl && reg_wdata[CB_START];
    assign start_img = reg_wdata[CB_IMG];
    assign clr       = wr_ctrl && reg_wdata[CB_CLR];

    // Writable configuration registers and the local reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q     <= 1'b0;
            soft_q    <= 1'b0;
            loc_rst_n <= 1'b0;
            base0     <= '0;
            cnt0      <= '0;
            base1     <= '0;
            cnt1      <= '0;
            scratch_q <= '0;
        end else begin
            loc_rst_n <= wr_ctrl ? !reg_wdata[CB_SOFT] : !soft_q;
            if (wr_ctrl) begin
                img_q  <= reg_wdata[CB_IMG];
                soft_q <= reg_wdata[CB_SOFT];
            end
            if (reg_wr && reg_addr == RA_BASE0)   base0     <= reg_wdata;
            if (reg_wr && reg_addr == RA_CNT0)    cnt0      <= reg_wdata;
            if (reg_wr && reg_addr == RA_BASE1)   base1     <= reg_wdata;
            if (reg_wr && reg_addr == RA_CNT1)    cnt1      <= reg_wdata;
            if (reg_wr && reg_addr == RA_SCRATCH) scratch_q <= reg_wdata;
        end
    end

    // Sticky status flags: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            if (fin_pulse)              done_q <= 1'b1;
            else if (clr || start_req)  done_q <= 1'b0;
            if (err_set)                err_q  <= 1'b1;
            else if (clr)               err_q  <= 1'b0;
            if (viol_set)               viol_q <= 1'b1;
            else if (clr)               viol_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_IMG]  = img_q;
                reg_rdata[CB_SOFT] = soft_q;
            end
            RA_STATUS: begin
                reg_rdata[0] = busy;
                reg_rdata[1] = done_q;
                reg_rdata[2] = err_q;
                reg_rdata[3] = viol_q;
            end
            RA_BASE0:   reg_rdata = base0;
            RA_CNT0:    reg_rdata = cnt0;
            RA_BASE1:   reg_rdata = base1;
            RA_CNT1:    reg_rdata = cnt1;
            RA_SCRATCH: reg_rdata = scratch_q;
            default:    reg_rdata = '0;
        endcase
    end

    // R4: a clear with no new violation leaves the flag low.
    a_r4_viol_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !viol_set) |=> !viol_q);
    // R8: done only rises after the sequencer's finish cycle.
    a_r8_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(fin_pulse));
endmodule

// File: rtl/cfgdma_seq.sv
// Load sequencer: reads an image word by word and emits two beats per word,
// low half first. Assumes memory returns read data one cycle after a request.
module cfgdma_seq
    import cfgdma_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int DW = DATA_W,
    parameter int BW = BEAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          start_img,
    input  logic [RW-1:0] base0,
    input  logic [RW-1:0] cnt0,
    input  logic [RW-1:0] base1,
    input  logic [RW-1:0] cnt1,
    input  logic [DW-1:0] mem_rdata,
    output logic          dma_req,
    output logic [RW-1:0] dma_addr,
    output logic          busy,
    output logic          fin_pulse,
    output logic          err_set,
    output logic [BW-1:0] prog_data,
    output logic          prog_valid,
    output logic          fpga_rst_n
);
    seq_state_t    state_q;
    logic [RW-1:0] ptr_q, left_q, sel_base, sel_cnt;
    logic [BW-1:0] hi_q;
    logic          last_word;

    // Pick the descriptor of the requested image.
    assign sel_base  = start_img ? base1 : base0;
    assign sel_cnt   = start_img ? cnt1 : cnt0;
    assign last_word = (left_q == RW'(1));
    assign busy      = (state_q != S_IDLE);
    assign fin_pulse = (state_q == S_FIN);
    assign err_set   = start_req && !busy && (sel_cnt == '0);
    assign dma_addr  = ptr_q;

    // Memory read issue: first word, then the next word overlapped with the high beat.
    always_comb begin
        dma_req = 1'b0;
        if (state_q == S_FETCH)                dma_req = 1'b1;
        else if (state_q == S_HI && !last_word) dma_req = 1'b1;
    end

    // State, address pointer, word counter and beat output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ptr_q      <= '0;
            left_q     <= '0;
            hi_q       <= '0;
            prog_data  <= '0;
            prog_valid <= 1'b0;
            fpga_rst_n <= 1'b1;
        end else begin
            case (state_q)
                S_IDLE: begin
                    prog_valid <= 1'b0;
                    if (start_req && sel_cnt != '0) begin
                        ptr_q      <= sel_base;
                        left_q     <= sel_cnt;
                        fpga_rst_n <= 1'b0;
                        state_q    <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    ptr_q      <= ptr_q + 1'b1;
                    prog_valid <= 1'b0;
                    state_q    <= S_LO;
                end
                S_LO: begin
                    prog_data  <= mem_rdata[BW-1:0];
                    hi_q       <= mem_rdata[DW-1:BW];
                    prog_valid <= 1'b1;
                    state_q    <= S_HI;
                end
                S_HI: begin
                    prog_data  <= hi_q;
                    prog_valid <= 1'b1;
                    left_q     <= left_q - 1'b1;
                    if (!last_word) begin
                        ptr_q   <= ptr_q + 1'b1;
                        state_q <= S_LO;
                    end else begin
                        state_q <= S_FIN;
                    end
                end
                S_FIN: begin
                    prog_valid <= 1'b0;
                    fpga_rst_n <= 1'b1;
                    state_q    <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R7: every beat goes out while the target is held in reset.
    a_r7_reset_during_beats: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |-> !fpga_rst_n);
    // R8: the finish cycle carries the final beat.
    a_r8_fin_has_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIN) |-> prog_valid);
    // R6: a low beat is always followed by its high beat.
    a_r6_beat_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LO) |=> prog_valid);
endmodule

// File: rtl/cfgdma_arb.sv
// Memory path arbiter: passes CPU accesses while idle, gives the path to the
// sequencer while busy and answers blocked CPU accesses with zero data.
module cfgdma_arb
    import cfgdma_pkg::*;
#(
    parameter int AW = REG_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ack,
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          viol_set
);
    logic blk_q;

    // Route the memory port to the current owner.
    assign mem_req   = busy ? dma_req : cpu_req;
    assign mem_we    = !busy && cpu_we;
    assign mem_addr  = busy ? dma_addr : cpu_addr;
    assign mem_wdata = cpu_wdata;
    assign viol_set  = busy && cpu_req;
    assign cpu_rdata = (cpu_ack && !blk_q) ? mem_rdata : '0;

    // Track acknowledge timing and whether the access was blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_ack <= 1'b0;
            blk_q   <= 1'b0;
        end else begin
            cpu_ack <= cpu_req;
            blk_q   <= cpu_req && busy;
        end
    end

    // R2: every acknowledge answers a request of the previous cycle.
    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> $past(cpu_req));
    // R3: an access made while busy returns zero data.
    a_r3_blocked_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && $past(busy)) |-> (cpu_rdata == '0));
endmodule

// File: rtl/cfgdma_top.sv
// Top level of the configuration image loader: ties together the register
// file, the load sequencer and the memory path arbiter.
module cfgdma_top
    import cfgdma_pkg::*;
#(
    parameter int RW  = REG_W,
    parameter int RAW = REG_AW,
    parameter int DW  = DATA_W,
    parameter int BW  = BEAT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RW-1:0]  reg_wdata,
    output logic [RW-1:0]  reg_rdata,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [RW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    output logic [DW-1:0]  cpu_rdata,
    output logic           cpu_ack,
    output logic           mem_req,
    output logic           mem_we,
    output logic [RW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [BW-1:0]  prog_data,
    output logic           prog_valid,
    output logic           fpga_rst_n,
    output logic           loc_rst_n
);
    logic          busy, fin_pulse, err_set, viol_set, start_req, start_img;
    logic          dma_req;
    logic [RW-1:0] dma_addr, base0, cnt0, base1, cnt1;

    cfgdma_regs #(.RW(RW), .RAW(RAW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .fin_pulse(fin_pulse), .err_set(err_set), .viol_set(viol_set),
        .start_req(start_req), .start_img(start_img), .base0(base0),
        .cnt0(cnt0), .base1(base1), .cnt1(cnt1), .loc_rst_n(loc_rst_n)
    );

    cfgdma_seq #(.RW(RW), .DW(DW), .BW(BW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_img(start_img),
        .base0(base0), .cnt0(cnt0), .base1(base1), .cnt1(cnt1),
        .mem_rdata(mem_rdata), .dma_req(dma_req), .dma_addr(dma_addr),
        .busy(busy), .fin_pulse(fin_pulse), .err_set(err_set),
        .prog_data(prog_data), .prog_valid(prog_valid), .fpga_rst_n(fpga_rst_n)
    );

    cfgdma_arb #(.AW(RW), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .dma_req(dma_req),
        .dma_addr(dma_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .viol_set(viol_set)
    );

    // R9: a rejected start never leaves the sequencer busy.
    a_r9_error_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> !busy);
    // R3: no memory write is issued while a load owns the path.
    a_r3_no_write_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
        !fpga_rst_n |-> !mem_we);
endmodule

// File: tb/cfgdma_top_tb.sv
module cfgdma_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = 8'd0;
    logic [31:0] cpu_wdata = 32'd0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic [15:0] prog_data;
    logic        prog_valid, fpga_rst_n, loc_rst_n;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] sram [256];

    // Loads: {image, base, count}
    localparam logic [16:0] LOADS [4] = '{
        {1'b0, 8'd10,  8'd3},
        {1'b1, 8'd40,  8'd5},
        {1'b0, 8'd254, 8'd4},
        {1'b1, 8'd100, 8'd8}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgdma_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .prog_data(prog_data), .prog_valid(prog_valid),
        .fpga_rst_n(fpga_rst_n), .loc_rst_n(loc_rst_n)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return {8'hB0 ^ a, a, ~a, a ^ 8'h3C};
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) sram[i] = pat(8'(i));
    end

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) sram[mem_addr] <= mem_wdata;
            mem_rdata <= sram[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cpu_access(input logic we, input logic [7:0] a, input logic [31:0] wd,
                              output logic [31:0] rd, output logic ack);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        rd  = cpu_rdata;
        ack = cpu_ack;
    endtask

    task automatic run_load(input logic img, input logic [7:0] base, input logic [7:0] cnt,
                            input bit poke);
        int idx = 0, first_t = -1, last_t = -1, done_t = -1, bad = 0, rst_bad = 0;
        logic [31:0] w, rd;
        logic [15:0] e, bad_act = '0, bad_exp = '0;
        logic busy_at_done = 1'b1, rst_at_done = 1'b0, ack;
        logic [7:0] st;
        reg_write(img ? 3'd4 : 3'd2, base);
        reg_write(img ? 3'd5 : 3'd3, cnt);
        reg_write(img ? 3'd2 : 3'd4, base + 8'd7);
        reg_write(img ? 3'd3 : 3'd5, cnt + 8'd1);
        reg_write(3'd0, {6'd0, img, 1'b1});
        reg_addr = 3'd1;
        #1;
        check(reg_rdata[0] == 1'b1 && reg_rdata[1] == 1'b0, "R8 busy set, done cleared after start",
              reg_rdata, 8'h01);
        check(fpga_rst_n == 1'b0, "R7 target reset asserted after start", fpga_rst_n, 0);
        for (int t = 1; t <= 2*int'(cnt) + 6 && done_t < 0; t++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 3'd1; cpu_req = 1'b0; cpu_we = 1'b0;
            #1;
            if (prog_valid) begin
                w = pat(base + 8'(idx / 2));
                e = (idx % 2 == 1) ? w[31:16] : w[15:0];
                if (prog_data !== e) begin
                    if (bad == 0) begin bad_act = prog_data; bad_exp = e; end
                    bad++;
                end
                if (first_t < 0) first_t = t;
                last_t = t;
                if (fpga_rst_n !== 1'b0) rst_bad++;
                idx++;
            end
            if (reg_rdata[1] && done_t < 0) begin
                done_t = t;
                busy_at_done = reg_rdata[0];
                rst_at_done = fpga_rst_n;
            end
            if (poke) begin
                case (t)
                    3: begin cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'hF0; end
                    4: begin
                        check(cpu_ack == 1'b1 && cpu_rdata == 32'd0, "R3 blocked read returns zero",
                              cpu_rdata, 0);
                        check(reg_rdata[3] == 1'b1, "R4 violation flag set", reg_rdata, 8'h09);
                        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'hF0; cpu_wdata = 32'hDEADBEEF;
                    end
                    5: begin reg_addr = 3'd0; reg_wr = 1'b1; reg_wdata = {6'd0, ~img, 1'b1}; end
                    6: begin reg_addr = 3'd6; reg_wr = 1'b1; reg_wdata = 8'h5C; end
                    default: ;
                endcase
            end
        end
        check(bad == 0, "R5 R6 beat data and order", bad_act, bad_exp);
        check(idx == 2*int'(cnt) && first_t == 2 && last_t == 2*int'(cnt) + 1,
              "R6 beat count and back-to-back timing", idx, 2*int'(cnt));
        check(rst_bad == 0, "R7 target reset held during beats", rst_bad, 0);
        check(done_t == last_t + 1 && busy_at_done == 1'b0 && rst_at_done == 1'b1,
              "R8 done one cycle after last beat", done_t, last_t + 1);
        if (poke) begin
            check(idx == 2*int'(cnt), "R10 restart during load ignored", idx, 2*int'(cnt));
            cpu_access(1'b0, 8'hF0, 32'd0, rd, ack);
            check(rd == pat(8'hF0), "R3 blocked write dropped", rd, pat(8'hF0));
            reg_read(3'd6, st);
            check(st == 8'h5C, "R1 scratch written during load", st, 8'h5C);
            reg_write(3'd0, 8'h08);
            reg_read(3'd1, st);
            check(st == 8'h00, "R4 clear wipes sticky flags", st, 8'h00);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic ack;
        logic [7:0] st;
        repeat (3) @(negedge clk);
        check(loc_rst_n == 1'b0, "R11 local reset low during rst_n", loc_rst_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(loc_rst_n == 1'b1, "R11 local reset released", loc_rst_n, 1);
        reg_read(3'd1, st);
        check(st == 8'h00 && !prog_valid && fpga_rst_n, "R12 reset state", st, 0);

        cpu_access(1'b1, 8'h80, 32'h12345678, rd, ack);
        check(ack == 1'b1, "R2 idle write acknowledged", ack, 1);
        cpu_access(1'b0, 8'h80, 32'd0, rd, ack);
        check(ack == 1'b1 && rd == 32'h12345678, "R2 idle read returns data", rd, 32'h12345678);
        cpu_access(1'b0, 8'h05, 32'd0, rd, ack);
        check(rd == pat(8'h05), "R2 idle read of staged word", rd, pat(8'h05));

        for (int i = 0; i < 4; i++) begin
            run_load(LOADS[i][16], LOADS[i][15:8], LOADS[i][7:0], i == 3);
        end

        reg_write(3'd3, 8'd0);
        reg_write(3'd0, 8'h01);
        reg_addr = 3'd1;
        #1;
        check(reg_rdata[2] == 1'b1 && reg_rdata[0] == 1'b0, "R9 zero count flags error",
              reg_rdata, 8'h04);
        begin
            int seen = 0;
            repeat (4) begin
                @(negedge clk);
                if (prog_valid || !fpga_rst_n) seen++;
            end
            check(seen == 0, "R9 zero count starts no load", seen, 0);
        end

        reg_write(3'd0, 8'h04);
        check(loc_rst_n == 1'b0, "R11 soft local reset asserted", loc_rst_n, 0);
        reg_write(3'd0, 8'h00);
        check(loc_rst_n == 1'b1, "R11 soft local reset released", loc_rst_n, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule